// File: doc/BRIEF.md
# Privileged Procedure Call Sequencer

This block runs the data side of a procedure-call instruction over several cycles. It has two variants: an ordinary call and a system call. The block receives the entry offset and the current program counter (P), environment word (E), local frame pointer (L) and stack pointer (S). It uses one single-port synchronous memory. Through that memory it reads the two boundary words at the base of code space and one word from the entry-point table. It then pushes the caller's context onto an upward-growing stack.

The block ends in one of two ways. It pulses `done_o` with the new register values, or it pulses `trap_o` and returns the input registers unchanged. A caller without privilege may raise its privilege by calling at or above the first callable offset. It traps when it calls at or above the first privileged offset. A caller that already holds privilege skips both boundary reads. The system-call variant also sets the kernel-space bit of E.

Top module: `proc_call_seq`

## Requirements
- R1: For an unprivileged caller (input E bit 15 clear), an offset greater than or equal to code word 1 gives a one-cycle `trap_o`. No memory write happens, and P/E/L/S outputs equal the inputs.
- R2: For an unprivileged caller, an offset below code word 1 and greater than or equal to code word 0 completes with output E bit 15 set.
- R3: For an unprivileged caller, an offset below code word 0 completes with output E bit 15 clear.
- R4: A caller with E bit 15 set never traps, keeps E bit 15 set, and makes exactly one memory read: the entry word.
- R5: A completed call writes input P to S+1, input E (unmodified) to S+2 and input L to S+3, in that order, and returns S+3 as the new S.
- R6: On completion, the new L equals the new S.
- R7: On completion, E bits 2:0 equal 7, and bits 13:3 equal their input values.
- R8: On completion, the new P equals the memory word at the address given by the offset.
- R9: A system call sets E bit 14. A plain call leaves E bit 14 at its input value.
- R10: `done_o` and `trap_o` are one-cycle pulses, never both high. A start pulse while `busy_o` is high is ignored.
- R11: During reset and after it, `busy_o`, `done_o`, `trap_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin a call (taken only when idle) |
| sys_call_i | input | 1 | 1 selects the system-call variant |
| offset_i | input | WORD_W | Entry offset of the callee |
| p_i | input | WORD_W | Current program counter |
| e_i | input | WORD_W | Current environment word |
| l_i | input | WORD_W | Current frame pointer |
| s_i | input | WORD_W | Current stack pointer |
| mem_req_o | output | 1 | Memory access this cycle |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | WORD_W | Word address |
| mem_wdata_o | output | WORD_W | Write data |
| mem_rdata_i | input | WORD_W | Read data, valid the cycle after the read request |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Call completed; outputs valid |
| trap_o | output | 1 | Protection trap raised |
| p_o | output | WORD_W | New program counter |
| e_o | output | WORD_W | New environment word |
| l_o | output | WORD_W | New frame pointer |
| s_o | output | WORD_W | New stack pointer |

## Verification
The hardest case is the set of offsets on either side of the two boundaries. These are the cases where a privilege raise and a trap meet, and they interact with whether the caller already holds privilege. The stimulus therefore sweeps every offset across both boundaries, for both variants and both caller privilege states. A second boundary setting then makes every offset callable. A start pulse injected mid-sequence with a trapping offset shows that the running call is not disturbed.

// File: rtl/pcall_pkg.sv
// Package: shared constants and the sequencer state type.
// Assumes the environment word is at least 16 bits wide.
package pcall_pkg;
    localparam int PRIV_BIT  = 15;
    localparam int SC_BIT    = 14;
    localparam int RP_W      = 3;
    localparam logic [RP_W-1:0] RP_EMPTY = 3'd7;
    localparam int HDR_CALLABLE_ADDR = 0;
    localparam int HDR_PRIV_ADDR     = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_PRIV,
        ST_RD_CALL,
        ST_RD_ENTRY,
        ST_PUSH_P,
        ST_PUSH_E,
        ST_PUSH_L
    } seq_state_t;
endpackage

// File: rtl/pcall_bound_cmp.sv
// Module: compares the call offset against a boundary word read from code space.
// Assumes both values are unsigned words of equal width.
module pcall_bound_cmp #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] offset_i,
    input  logic [WORD_W-1:0] bound_i,
    output logic              at_or_above_o
);
    // Purpose: unsigned greater-or-equal test.
    always_comb begin
        at_or_above_o = (offset_i >= bound_i);
    end
endmodule

// File: rtl/pcall_e_update.sv
// Module: builds the environment word returned by a completed call.
// Assumes WORD_W >= 16. Bits outside the privilege bit, the kernel bit
// and the register-stack pointer pass through unchanged.
module pcall_e_update #(
    parameter int WORD_W = 16
) (
    input  logic [WORD_W-1:0] old_e_i,
    input  logic              raise_priv_i,
    input  logic              sys_call_i,
    output logic [WORD_W-1:0] new_e_o
);
    import pcall_pkg::*;

    // Purpose: merge privilege, kernel-space and empty-stack fields.
    always_comb begin
        new_e_o = old_e_i;
        if (raise_priv_i) new_e_o[PRIV_BIT] = 1'b1;
        if (sys_call_i)   new_e_o[SC_BIT]   = 1'b1;
        new_e_o[RP_W-1:0] = RP_EMPTY;
    end
endmodule

// File: rtl/pcall_ctrl.sv
// Module: state machine that orders the boundary reads, the entry read and
// the three stack pushes, and registers the results.
// Assumes synchronous memory: read data arrives the cycle after the request.
module pcall_ctrl #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sys_call_i,
    input  logic [WORD_W-1:0] offset_i,
    input  logic [WORD_W-1:0] p_i,
    input  logic [WORD_W-1:0] e_i,
    input  logic [WORD_W-1:0] l_i,
    input  logic [WORD_W-1:0] s_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    input  logic              ge_bound_i,
    input  logic [WORD_W-1:0] e_new_i,
    output logic [WORD_W-1:0] offset_q_o,
    output logic [WORD_W-1:0] e_q_o,
    output logic              raise_q_o,
    output logic              sys_q_o,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    output logic              busy_o,
    output logic              done_o,
    output logic              trap_o,
    output logic [WORD_W-1:0] p_o,
    output logic [WORD_W-1:0] e_o,
    output logic [WORD_W-1:0] l_o,
    output logic [WORD_W-1:0] s_o
);
    import pcall_pkg::*;

    localparam logic [WORD_W-1:0] ONE       = WORD_W'(1);
    localparam logic [WORD_W-1:0] ADDR_CALL = WORD_W'(HDR_CALLABLE_ADDR);
    localparam logic [WORD_W-1:0] ADDR_PRIV = WORD_W'(HDR_PRIV_ADDR);

    seq_state_t        state_q;
    logic [WORD_W-1:0] p_q, l_q, sp_q, newp_q;

    assign offset_q_o = offset_q_o_r;
    logic [WORD_W-1:0] offset_q_o_r;
    assign busy_o     = (state_q != ST_IDLE);

    // Purpose: drive the memory port from the current state.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (state_q)
            ST_RD_PRIV:  begin mem_req_o = 1'b1; mem_addr_o = ADDR_PRIV; end
            ST_RD_CALL:  begin mem_req_o = 1'b1; mem_addr_o = ADDR_CALL; end
            ST_RD_ENTRY: begin mem_req_o = 1'b1; mem_addr_o = offset_q_o_r; end
            ST_PUSH_P:   begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                               mem_addr_o = sp_q + ONE; mem_wdata_o = p_q; end
            ST_PUSH_E:   begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                               mem_addr_o = sp_q + ONE; mem_wdata_o = e_q_o; end
            ST_PUSH_L:   begin mem_req_o = 1'b1; mem_we_o = 1'b1;
                               mem_addr_o = sp_q + ONE; mem_wdata_o = l_q; end
            default: ;
        endcase
    end

    // Purpose: advance the sequence and register captured values and results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            offset_q_o_r <= '0;
            p_q          <= '0;
            e_q_o        <= '0;
            l_q          <= '0;
            sp_q         <= '0;
            newp_q       <= '0;
            raise_q_o    <= 1'b0;
            sys_q_o      <= 1'b0;
            done_o       <= 1'b0;
            trap_o       <= 1'b0;
            p_o          <= '0;
            e_o          <= '0;
            l_o          <= '0;
            s_o          <= '0;
        end else begin
            done_o <= 1'b0;
            trap_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    offset_q_o_r <= offset_i;
                    p_q          <= p_i;
                    e_q_o        <= e_i;
                    l_q          <= l_i;
                    sp_q         <= s_i;
                    sys_q_o      <= sys_call_i;
                    raise_q_o    <= 1'b0;
                    state_q      <= e_i[PRIV_BIT] ? ST_RD_ENTRY : ST_RD_PRIV;
                end
                ST_RD_PRIV: state_q <= ST_RD_CALL;
                ST_RD_CALL: begin
                    if (ge_bound_i) begin
                        trap_o  <= 1'b1;
                        p_o     <= p_q;
                        e_o     <= e_q_o;
                        l_o     <= l_q;
                        s_o     <= sp_q;
                        state_q <= ST_IDLE;
                    end else begin
                        state_q <= ST_RD_ENTRY;
                    end
                end
                ST_RD_ENTRY: begin
                    if (!e_q_o[PRIV_BIT] && ge_bound_i) raise_q_o <= 1'b1;
                    state_q <= ST_PUSH_P;
                end
                ST_PUSH_P: begin
                    newp_q  <= mem_rdata_i;
                    sp_q    <= sp_q + ONE;
                    state_q <= ST_PUSH_E;
                end
                ST_PUSH_E: begin
                    sp_q    <= sp_q + ONE;
                    state_q <= ST_PUSH_L;
                end
                ST_PUSH_L: begin
                    sp_q    <= sp_q + ONE;
                    done_o  <= 1'b1;
                    p_o     <= newp_q;
                    e_o     <= e_new_i;
                    l_o     <= sp_q + ONE;
                    s_o     <= sp_q + ONE;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/proc_call_seq.sv
// Module: top of the call sequencer. Wires the controller to the boundary
// comparator and the environment-word builder.
// Assumes one single-port synchronous memory shared by code and stack space.
module proc_call_seq #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sys_call_i,
    input  logic [WORD_W-1:0] offset_i,
    input  logic [WORD_W-1:0] p_i,
    input  logic [WORD_W-1:0] e_i,
    input  logic [WORD_W-1:0] l_i,
    input  logic [WORD_W-1:0] s_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [WORD_W-1:0] mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              trap_o,
    output logic [WORD_W-1:0] p_o,
    output logic [WORD_W-1:0] e_o,
    output logic [WORD_W-1:0] l_o,
    output logic [WORD_W-1:0] s_o
);
    logic [WORD_W-1:0] offset_q, e_q, e_new;
    logic              raise_q, sys_q, ge_bound;

    pcall_bound_cmp #(.WORD_W(WORD_W)) cmp_i (
        .offset_i      (offset_q),
        .bound_i       (mem_rdata_i),
        .at_or_above_o (ge_bound)
    );

    pcall_e_update #(.WORD_W(WORD_W)) eupd_i (
        .old_e_i      (e_q),
        .raise_priv_i (raise_q),
        .sys_call_i   (sys_q),
        .new_e_o      (e_new)
    );

    pcall_ctrl #(.WORD_W(WORD_W)) ctrl_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .sys_call_i  (sys_call_i),
        .offset_i    (offset_i),
        .p_i         (p_i),
        .e_i         (e_i),
        .l_i         (l_i),
        .s_i         (s_i),
        .mem_rdata_i (mem_rdata_i),
        .ge_bound_i  (ge_bound),
        .e_new_i     (e_new),
        .offset_q_o  (offset_q),
        .e_q_o       (e_q),
        .raise_q_o   (raise_q),
        .sys_q_o     (sys_q),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .trap_o      (trap_o),
        .p_o         (p_o),
        .e_o         (e_o),
        .l_o         (l_o),
        .s_o         (s_o)
    );
endmodule

// File: rtl/pcall_sva.sv
// Module: assertion checker bound to proc_call_seq; observes ports only.
module pcall_sva #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req_o,
    input logic              mem_we_o,
    input logic              busy_o,
    input logic              done_o,
    input logic              trap_o,
    input logic [WORD_W-1:0] e_o,
    input logic [WORD_W-1:0] l_o,
    input logic [WORD_W-1:0] s_o
);
    // R7: the register-stack pointer is empty after every completed call
    assert_rp_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> e_o[2:0] == 3'd7);

    // R6: the frame pointer follows the new stack pointer
    assert_frame_link_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> l_o == s_o);

    // R10: completion and trap are exclusive
    assert_done_trap_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && trap_o));

    // R10: completion is a single-cycle pulse
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R10: trap is a single-cycle pulse
    assert_trap_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |=> !trap_o);

    // R11: memory is only touched while a sequence runs
    assert_mem_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |-> busy_o);

    // R5: a write is always part of a request
    assert_we_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> mem_req_o);
endmodule

bind proc_call_seq pcall_sva #(.WORD_W(WORD_W)) sva_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_req_o (mem_req_o),
    .mem_we_o  (mem_we_o),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .trap_o    (trap_o),
    .e_o       (e_o),
    .l_o       (l_o),
    .s_o       (s_o)
);

// File: tb/proc_call_seq_tb_top.sv
// Bench: sweeps offsets across both boundaries for both variants and both
// caller privilege states, against a behavioural synchronous RAM.
module proc_call_seq_tb_top;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0, sys_call_i = 1'b0;
    logic [W-1:0] offset_i = '0, p_i = '0, e_i = '0, l_i = '0, s_i = '0;
    logic         mem_req_o, mem_we_o, busy_o, done_o, trap_o;
    logic [W-1:0] mem_addr_o, mem_wdata_o, p_o, e_o, l_o, s_o;
    logic [W-1:0] mem_rdata_i = '0;

    logic [W-1:0] ram [256];
    int rd_cnt = 0, wr_cnt = 0;
    int errors = 0, checks = 0;

    always #4 clk = ~clk;

    proc_call_seq #(.WORD_W(W)) dut_i (.*);

    // Purpose: behavioural single-port RAM with access counters.
    always @(posedge clk) begin
        if (mem_req_o) begin
            if (mem_we_o) begin
                ram[mem_addr_o[7:0]] <= mem_wdata_o;
                wr_cnt <= wr_cnt + 1;
            end else begin
                mem_rdata_i <= ram[mem_addr_o[7:0]];
                rd_cnt <= rd_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] entry_word(input int off);
        return W'(16'h1000 + off * 3);
    endfunction

    task automatic load_table(input logic [W-1:0] fc, input logic [W-1:0] fp);
        for (int a = 0; a < 256; a++) ram[a] = entry_word(a);
        ram[0] = fc;
        ram[1] = fp;
    endtask

    task automatic run_call(input int off, input bit sy, input bit pv,
                            input logic [W-1:0] fc, input logic [W-1:0] fp,
                            input bit poke_busy);
        logic [W-1:0] pin, ein, lin, sin, eexp, entry0;
        int rd0, wr0, waited;
        bit exp_trap, raise;
        pin = W'(16'hA000 + off);
        ein = W'(off * 1237 + 5);
        ein[15] = pv;
        ein[14] = off[0];
        lin = W'(16'h0300 + off * 7);
        sin = W'(16'h0090 + (off % 64));
        entry0 = (off == 0) ? fc : (off == 1) ? fp : entry_word(off);
        exp_trap = !pv && (W'(off) >= fp);
        raise    = !pv && (W'(off) >= fc);
        @(negedge clk);
        rd0 = rd_cnt; wr0 = wr_cnt;
        start_i = 1'b1; sys_call_i = sy; offset_i = W'(off);
        p_i = pin; e_i = ein; l_i = lin; s_i = sin;
        @(negedge clk);
        start_i = 1'b0;
        offset_i = 16'hFFFF; p_i = '0; e_i = '0; l_i = '0; s_i = '0;
        if (poke_busy) begin
            @(negedge clk);
            start_i = 1'b1; offset_i = 16'd70;   // R10: ignored while busy
            @(negedge clk);
            start_i = 1'b0;
        end
        waited = 0;
        while (!done_o && !trap_o && waited < 40) begin
            @(negedge clk);
            waited++;
        end
        if (waited >= 40) begin
            errors++; checks++;
            $display("FAIL R10: no completion for offset %0d", off);
            return;
        end
        if (exp_trap) begin
            check("R1 trap", {15'd0, trap_o}, 16'd1);
            check("R1 p", p_o, pin);
            check("R1 e", e_o, ein);
            check("R1 l", l_o, lin);
            check("R1 s", s_o, sin);
            check("R1 writes", W'(wr_cnt - wr0), 16'd0);
        end else begin
            eexp = ein;
            if (raise) eexp[15] = 1'b1;
            if (sy) eexp[14] = 1'b1;
            eexp[2:0] = 3'd7;
            check("R10 done", {15'd0, done_o}, 16'd1);
            check("R8 p", p_o, entry0);
            check(pv ? "R4 e" : raise ? "R2 e" : "R3 e", {15'd0, e_o[15]}, {15'd0, eexp[15]});
            check("R9 sc", {15'd0, e_o[14]}, {15'd0, eexp[14]});
            check("R7 e", e_o, eexp);
            check("R5 s", s_o, sin + 16'd3);
            check("R6 l", l_o, sin + 16'd3);
            check("R5 push P", ram[sin[7:0] + 8'd1], pin);
            check("R5 push E", ram[sin[7:0] + 8'd2], ein);
            check("R5 push L", ram[sin[7:0] + 8'd3], lin);
            check("R5 writes", W'(wr_cnt - wr0), 16'd3);
            if (pv) check("R4 reads", W'(rd_cnt - rd0), 16'd1);
        end
        @(negedge clk);
        check("R10 pulse", {14'd0, done_o, trap_o}, 16'd0);
        check("R10 idle", {15'd0, busy_o}, 16'd0);
    endtask

    initial begin
        #(8 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: run did not end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        load_table(16'd40, 16'd60);
        repeat (3) @(negedge clk);
        check("R11 busy", {15'd0, busy_o}, 16'd0);
        check("R11 pulses", {14'd0, done_o, trap_o}, 16'd0);
        check("R11 mem", {15'd0, mem_req_o}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R11 after reset", {13'd0, busy_o, mem_req_o, done_o}, 16'd0);

        for (int off = 0; off < 80; off++)
            for (int sy = 0; sy < 2; sy++)
                for (int pv = 0; pv < 2; pv++)
                    run_call(off, sy[0], pv[0], 16'd40, 16'd60, 1'b0);

        run_call(5, 1'b0, 1'b0, 16'd40, 16'd60, 1'b1);   // R10 start while busy
        run_call(50, 1'b1, 1'b0, 16'd40, 16'd60, 1'b1);

        load_table(16'd0, 16'hFFFF);
        for (int off = 2; off < 12; off++)
            run_call(off, 1'b0, 1'b0, 16'd0, 16'hFFFF, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule